// File: doc/BRIEF.md
# DAC Load Sense Sequencer

This block holds the control and status used to find out which of three video DAC outputs has a monitor load attached. A host writes a sense request bit through a small register port. While the request is high, every DAC data bus carries a fixed full-scale test code instead of pixel data. Clearing the request starts the measurement. One clock later the block samples three digital comparator results, one per channel, and stores them as termination status.

A measurement counts only when all three DACs are powered on and the routing-mode bit is 0. A valid flag shows whether the stored status came from such a measurement. Any write that alters the power enables or the mode bit clears the flag. Analog comparison, the DACs and the reference voltage lie outside the block. The comparator results arrive as synchronous inputs.

Top module: `dac_load_sense`

## Requirements
- R1: After reset the sense request, mode bit, power enables, status bits and valid flag are all 0.
- R2: While the sense request is 0, each channel's DAC output equals that channel's pixel input.
- R3: From the cycle after a write sets the sense request, each of the three DAC outputs carries the all-ones code (0x3FF for a 10-bit bus), whatever the pixel inputs are.
- R4: A write that clears a set sense request at clock edge k makes the block sample the comparator inputs at edge k+1. The sampled value is the status from then on, with bit i set when channel i is loaded.
- R5: If the power enables are not 3'b111, or the mode bit is 1, during the capture cycle, the status bits are left unchanged and the valid flag stays 0.
- R6: A qualified capture with no configuration change at the same edge sets the valid flag to 1.
- R7: A write that changes the power enables or the mode bit clears the valid flag at that edge. Writing the value already held leaves the flag unchanged.
- R8: Register map. Address 0 is control: bit 0 is the sense request and bit 1 is the mode bit. Address 1 holds the power enables in bits 2:0. Address 2 is read-only status and reads as {valid, 4'b0, status[2:0]}. Reads return zeros in unused bit positions.
- R9: Status bits change only at a capture. Comparator activity while the request is high has no effect, and neither does a write of 0 to an already clear request.
- R10: Address 3 reads as 0. Writes to address 2 or 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| pix_in | input | 30 | Pixel data, channel i in bits [10i+9:10i] |
| cmp_in | input | 3 | Comparator results, bit i for channel i, 1 = loaded |
| dac_out | output | 30 | DAC data, channel i in bits [10i+9:10i] |

## Verification
The hardest case to reach is the single cycle after the clearing write, when the comparator inputs count. The bench holds the comparator inputs at the complement of the expected pattern at all other times and presents the real pattern only in that one cycle, so sampling one edge early or late shows up as wrong status. It also reaches unqualified captures by stepping power and mode through partial settings between sequences, which makes a stale but unchanged status and a cleared flag visible together.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int unsigned NCH    = 3;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_PWR  = 2'd1,
        A_STAT = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic mode;
        logic sense;
    } ctrl_t;

    typedef struct packed {
        logic           valid;
        logic [NCH-1:0] bits;
    } status_t;

    function automatic logic sense_allowed(input logic [NCH-1:0] pwr, input logic mode);
        return (&pwr) && !mode;
    endfunction

endpackage

// File: rtl/dls_regs.sv
module dls_regs
    import dls_pkg::*;
#(
    parameter int unsigned RW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [RW-1:0]        wdata,
    input  status_t              stat,
    output ctrl_t                ctrl,
    output logic [NCH-1:0]       pwr,
    output logic                 cfg_chg,
    output logic [RW-1:0]        rdata
);
    localparam int unsigned PAD_S = RW - 1 - NCH;
    localparam int unsigned PAD_C = RW - 2;
    localparam int unsigned PAD_P = RW - NCH;

    logic wr_ctrl, wr_pwr;
    logic unused_wdata;

    assign wr_ctrl      = wr_en && (addr == A_CTRL);
    assign wr_pwr       = wr_en && (addr == A_PWR);
    assign unused_wdata = ^wdata[RW-1:NCH];

    assign cfg_chg = (wr_ctrl && (wdata[1] != ctrl.mode)) ||
                     (wr_pwr  && (wdata[NCH-1:0] != pwr));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            pwr  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.sense <= wdata[0];
                ctrl.mode  <= wdata[1];
            end
            if (wr_pwr) begin
                pwr <= wdata[NCH-1:0];
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {{PAD_C{1'b0}}, ctrl.mode, ctrl.sense};
            A_PWR:   rdata = {{PAD_P{1'b0}}, pwr};
            A_STAT:  rdata = {stat.valid, {PAD_S{1'b0}}, stat.bits};
            default: rdata = '0;
        endcase
    end

    // R10
    no_stat_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == A_STAT || addr == A_NONE)) |=> ($stable(ctrl) && $stable(pwr)));

endmodule

// File: rtl/dls_edge.sv
module dls_edge (
    input  logic clk,
    input  logic rst,
    input  logic sense,
    output logic fall
);
    logic sense_d;

    always_ff @(posedge clk) begin
        if (rst) sense_d <= 1'b0;
        else     sense_d <= sense;
    end

    assign fall = sense_d && !sense;

endmodule

// File: rtl/dls_capture.sv
module dls_capture
    import dls_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fall,
    input  logic [NCH-1:0]  pwr,
    input  logic            mode,
    input  logic            cfg_chg,
    input  logic [NCH-1:0]  cmp,
    output status_t         stat
);
    logic qual;

    assign qual = fall && sense_allowed(pwr, mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            if (qual) stat.bits <= cmp;
            if (cfg_chg)   stat.valid <= 1'b0;
            else if (qual) stat.valid <= 1'b1;
        end
    end

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(stat.bits));

    // R5
    unqual_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && !sense_allowed(pwr, mode)) |=> ($stable(stat.bits) && !stat.valid));

    // R6
    valid_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && sense_allowed(pwr, mode) && !cfg_chg) |=> (stat.valid && stat.bits == $past(cmp)));

    // R7
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_chg |=> !stat.valid);

endmodule

// File: rtl/dls_drive.sv
module dls_drive
    import dls_pkg::*;
#(
    parameter int unsigned DW = 10
) (
    input  logic              sense,
    input  logic [NCH*DW-1:0] pix,
    output logic [NCH*DW-1:0] dac
);
    localparam logic [DW-1:0] TEST_CODE = '1;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign dac[ch*DW +: DW] = sense ? TEST_CODE : pix[ch*DW +: DW];
    end

endmodule

// File: rtl/dac_load_sense.sv
module dac_load_sense
    import dls_pkg::*;
#(
    parameter int unsigned DW = 10,
    parameter int unsigned RW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [RW-1:0]        reg_wdata,
    output logic [RW-1:0]        reg_rdata,
    input  logic [NCH*DW-1:0]    pix_in,
    input  logic [NCH-1:0]       cmp_in,
    output logic [NCH*DW-1:0]    dac_out
);
    ctrl_t          ctrl;
    logic [NCH-1:0] pwr;
    logic           cfg_chg;
    logic           fall;
    status_t        stat;

    dls_regs #(.RW(RW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .stat    (stat),
        .ctrl    (ctrl),
        .pwr     (pwr),
        .cfg_chg (cfg_chg),
        .rdata   (reg_rdata)
    );

    dls_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .sense (ctrl.sense),
        .fall  (fall)
    );

    dls_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .fall    (fall),
        .pwr     (pwr),
        .mode    (ctrl.mode),
        .cfg_chg (cfg_chg),
        .cmp     (cmp_in),
        .stat    (stat)
    );

    dls_drive #(.DW(DW)) u_drive (
        .sense (ctrl.sense),
        .pix   (pix_in),
        .dac   (dac_out)
    );

    // R3
    test_code_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[0]) |=> (&dac_out));

    // R4
    fall_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[0] && ctrl.sense) |=> fall);

endmodule

// File: tb/dac_load_sense_bench.sv
module dac_load_sense_bench;

    localparam int unsigned DW = 10;
    localparam int unsigned RW = 8;
    localparam logic [DW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic [3*DW-1:0] pix_in = '0;
    logic [2:0]    cmp_in = '0;
    logic [3*DW-1:0] dac_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dac_load_sense #(.DW(DW), .RW(RW)) u_dac_load_sense (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pix_in (pix_in), .cmp_in (cmp_in), .dac_out (dac_out)
    );

    // {pwr[2:0], mode, cmp[2:0], exp_status[2:0], exp_valid}
    localparam logic [10:0] VEC [0:7] = '{
        {3'b111, 1'b0, 3'b101, 3'b101, 1'b1},
        {3'b111, 1'b0, 3'b010, 3'b010, 1'b1},
        {3'b011, 1'b0, 3'b111, 3'b010, 1'b0},
        {3'b111, 1'b1, 3'b111, 3'b010, 1'b0},
        {3'b111, 1'b0, 3'b111, 3'b111, 1'b1},
        {3'b111, 1'b0, 3'b000, 3'b000, 1'b1},
        {3'b110, 1'b0, 3'b011, 3'b000, 1'b0},
        {3'b111, 1'b0, 3'b110, 3'b110, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R8: reset state through the register port
        rd(2'd0, r); chk("R1 ctrl after reset", r, 8'h00);
        rd(2'd1, r); chk("R1 pwr after reset", r, 8'h00);
        rd(2'd2, r); chk("R1 status after reset", r, 8'h00);
        // R10: unmapped read
        rd(2'd3, r); chk("R10 unmapped read", r, 8'h00);

        // R2: pass-through, two patterns
        pix_in = {10'h155, 10'h2AA, 10'h0F0}; #1;
        chk("R2 pass pattern A", dac_out, {10'h155, 10'h2AA, 10'h0F0});
        pix_in = {10'h001, 10'h3FE, 10'h200}; #1;
        chk("R2 pass pattern B", dac_out, {10'h001, 10'h3FE, 10'h200});

        // Vector table: full sense sequences
        for (int i = 0; i < 8; i++) begin
            logic [2:0] vp, vc, es;
            logic       vm, ev;
            {vp, vm, vc, es, ev} = VEC[i];
            cmp_in = ~vc;
            wr(2'd1, {5'b0, vp});
            wr(2'd0, {6'b0, vm, 1'b1});
            // R3: test code while sense high
            chk("R3 test code", dac_out, {ONES, ONES, ONES});
            wr(2'd0, {6'b0, vm, 1'b0});
            cmp_in = vc;           // only this cycle counts (R4)
            @(posedge clk);
            #1 cmp_in = ~vc;
            rd(2'd2, r);
            chk("R4/R5 status bits", {29'b0, r[2:0]}, {29'b0, es});
            chk("R6/R5 valid flag", {31'b0, r[7]}, {31'b0, ev});
            chk("R8 status pad bits", {28'b0, r[6:3]}, 32'd0);
        end
        // state: pwr 111, mode 0, status 110, valid 1

        // R8: readback of ctrl and pwr
        rd(2'd1, r); chk("R8 pwr readback", r, 8'h07);
        rd(2'd0, r); chk("R8 ctrl readback", r, 8'h00);

        // R9: clear write with sense already 0 causes no capture
        cmp_in = 3'b001;
        wr(2'd0, 8'h00);
        @(posedge clk); #1;
        rd(2'd2, r); chk("R9 no capture on idle clear", r, 8'h86);

        // R9: comparator activity while sense high ignored
        wr(2'd0, 8'h01);
        cmp_in = 3'b011; @(posedge clk); #1;
        cmp_in = 3'b100; @(posedge clk); #1;
        rd(2'd2, r); chk("R9 status held while sensing", r, 8'h86);
        cmp_in = 3'b110;
        wr(2'd0, 8'h00);
        @(posedge clk); #1;

        // R7: rewriting same pwr keeps valid
        wr(2'd1, 8'h07);
        rd(2'd2, r); chk("R7 same value keeps valid", r, 8'h86);

        // R10: writes to status and unmapped address ignored
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd2, r); chk("R10 status write ignored", r, 8'h86);
        rd(2'd0, r); chk("R10 ctrl untouched", r, 8'h00);
        rd(2'd1, r); chk("R10 pwr untouched", r, 8'h07);
        rd(2'd3, r); chk("R10 unmapped still zero", r, 8'h00);
        chk("R2 pass after writes", dac_out, {10'h001, 10'h3FE, 10'h200});

        // R7: changing pwr clears valid, status kept
        wr(2'd1, 8'h05);
        rd(2'd2, r); chk("R7 pwr change clears valid", r, 8'h06);

        // R7: mode change clears valid after a fresh capture
        wr(2'd1, 8'h07);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        cmp_in = 3'b011;
        @(posedge clk); #1 cmp_in = 3'b000;
        rd(2'd2, r); chk("R6 recapture", r, 8'h83);
        wr(2'd0, 8'h02);
        rd(2'd2, r); chk("R7 mode change clears valid", r, 8'h03);

        // R1: reset mid-run
        wr(2'd0, 8'h01);
        rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        rd(2'd2, r); chk("R1 status after late reset", r, 8'h00);
        rd(2'd0, r); chk("R1 ctrl after late reset", r, 8'h00);
        chk("R1 drive back to pixels", dac_out, {10'h001, 10'h3FE, 10'h200});

        finish_run();
    end

endmodule